// File: doc/BRIEF.md
# Paged Address Translator with Fault Isolation

This block sits between an 8-bit processor with a 16-bit address bus and a 20-bit physical memory. Each processor access is split into a 256-byte page number and an in-page offset. The page number, together with the number of the active mapping table, indexes a translation store. Each entry holds a physical page number and the valid, read and write permission bits. The offset passes through untouched. Accesses that pass the checks are issued to memory one cycle after the request. Read data reaches the processor one cycle after that.

When an access breaks the permissions, the unit requests a non-maskable interrupt. It also arms an isolation flip-flop and switches to a dead table. The processor still finishes its instruction, so the rest of that instruction's bus cycles take place, but none of them reach memory and reads return zero. This matters for an instruction whose opcode is on a permitted page and whose operand bytes are on a forbidden page. Because operand reads return zero, its store would otherwise land at a wrong address. The processor's read of the interrupt vector at 0xFFFA ends the isolation and selects a handler table. The table that was active at the fault is kept for the handler to read. A small register port, open only while the handler table is active, loads table entries and chooses the active table.

Top module: `page_guard_mmu`

## Requirements
- R1: A permitted access issued in one cycle drives `mem_en` in the next cycle with `mem_addr = {physical page, cpu_addr[7:0]}`. For a write, `mem_we` is high and `mem_wdata` carries the written byte; `mem_we` is never high without `mem_en`.
- R2: For a permitted read, `cpu_rdata` takes the value of `mem_rdata` on the clock edge that ends the memory cycle, which is two edges after the request.
- R3: A read of a page whose read bit is 0 gives no `mem_en`, sets `cpu_rdata` to 0x00 and counts as a fault.
- R4: A write to a page whose write bit is 0 gives no `mem_en` or `mem_we` and counts as a fault. A write to a page with only the write bit set goes through.
- R5: Any access through an entry whose valid bit is 0, or through the dead table (number 3), gives no memory access and counts as a fault.
- R6: After a fault, every later read and write is blocked: no `mem_en`, and reads return 0x00. This lasts until the vector read and includes the remaining cycles of the faulting instruction.
- R7: One cycle after a fault, `nmi_req` is high, the active table is 3 (dead), and the saved fault table holds the number of the table the faulting access used.
- R8: A processor read of 0xFFFA is translated through table 2 (handler). On that edge it clears the isolation, drops `nmi_req` and makes table 2 active.
- R9: Register-port writes take effect only while table 2 is active. At any other time they change neither the tables nor the selection.
- R10: After reset, table 2 is active, `nmi_req` is low and no memory access is issued. Register codes: 0 page index, 1 target table, 2 physical page low byte, 3 commit entry (bit 7 valid, bit 6 write, bit 5 read, bits 3:0 physical page high bits) to the target table at the index, 4 select active table (bits 1:0).
- R11: `cfg_rdata` is registered. With `cfg_addr` = 5 it returns the saved fault table. With any other code it returns the active table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor logical address |
| cpu_rd | input | 1 | Processor read request |
| cpu_wr | input | 1 | Processor write request |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Read data returned to the processor |
| nmi_req | output | 1 | Non-maskable interrupt request |
| mem_addr | output | 20 | Physical address |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid while mem_en is high |
| cfg_wr | input | 1 | Register port write strobe |
| cfg_addr | input | 3 | Register code |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |

## Verification
Table 0 maps every page to a scrambled physical page. Full read and write sweeps over every page show whether the page number and the offset reach `mem_addr` in the right bit places, and whether the read data is returned in the right cycle. Single accesses to read-only, write-only and invalid entries tell the three permission checks apart. A selected dead table shows that its entries are ignored. A back-to-back run of opcode read, forbidden operand reads and a store shows that isolation holds within one instruction, and an attempt to reconfigure while locked shows that the lock works. Each fault is followed by a vector read, which checks the handover to the handler table and the saved table number.

// File: rtl/pgmmu_pkg.sv
package pgmmu_pkg;
  typedef enum logic [2:0] {
    REG_IDX    = 3'd0,
    REG_TGT    = 3'd1,
    REG_PPNL   = 3'd2,
    REG_COMMIT = 3'd3,
    REG_SEL    = 3'd4,
    REG_INFO   = 3'd5
  } cfg_reg_e;
endpackage

// File: rtl/pgmmu_xlat_ram.sv
module pgmmu_xlat_ram #(
  parameter int AW = 10,
  parameter int DW = 15
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/pgmmu_cfg.sv
module pgmmu_cfg
  import pgmmu_pkg::*;
#(
  parameter int VPN_W = 8,
  parameter int PPN_W = 12,
  parameter int TBL_W = 2,
  parameter int DW    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic [2:0]             addr,
  input  logic [DW-1:0]          wdata,
  input  logic                   unlocked,
  output logic                   commit_we,
  output logic [TBL_W+VPN_W-1:0] commit_addr,
  output logic [PPN_W+2:0]       commit_data,
  output logic                   sel_we,
  output logic [TBL_W-1:0]       sel_tbl
);
  localparam int HI_W = PPN_W - DW;

  logic [VPN_W-1:0] idx_q;
  logic [TBL_W-1:0] tgt_q;
  logic [DW-1:0]    ppnl_q;
  logic             wr_ok;
  logic             unused_cfg_bits;

  assign wr_ok = wr && unlocked;
  assign unused_cfg_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      tgt_q  <= '0;
      ppnl_q <= '0;
    end else if (wr_ok) begin
      case (cfg_reg_e'(addr))
        REG_IDX:  idx_q  <= wdata[VPN_W-1:0];
        REG_TGT:  tgt_q  <= wdata[TBL_W-1:0];
        REG_PPNL: ppnl_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    commit_we   = wr_ok && (addr == REG_COMMIT);
    commit_addr = {tgt_q, idx_q};
    commit_data = {wdata[7], wdata[6], wdata[5], wdata[HI_W-1:0], ppnl_q};
    sel_we      = wr_ok && (addr == REG_SEL);
    sel_tbl     = wdata[TBL_W-1:0];
  end
endmodule

// File: rtl/pgmmu_fault_ctl.sv
module pgmmu_fault_ctl #(
  parameter int               TBL_W    = 2,
  parameter logic [TBL_W-1:0] HND_TBL  = 2,
  parameter logic [TBL_W-1:0] DEAD_TBL = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_evt,
  input  logic [TBL_W-1:0] fault_tbl,
  input  logic             vec_hit,
  input  logic             sel_we,
  input  logic [TBL_W-1:0] sel_tbl,
  output logic [TBL_W-1:0] active_tbl,
  output logic [TBL_W-1:0] saved_tbl,
  output logic             iso_q
);
  // A new fault outranks the vector read; the vector read outranks a select.
  always_ff @(posedge clk) begin
    if (rst) begin
      active_tbl <= HND_TBL;
      saved_tbl  <= '0;
      iso_q      <= 1'b0;
    end else if (fault_evt) begin
      active_tbl <= DEAD_TBL;
      saved_tbl  <= fault_tbl;
      iso_q      <= 1'b1;
    end else if (vec_hit) begin
      active_tbl <= HND_TBL;
      iso_q      <= 1'b0;
    end else if (sel_we) begin
      active_tbl <= sel_tbl;
    end
  end
endmodule

// File: rtl/page_guard_mmu.sv
module page_guard_mmu
  import pgmmu_pkg::*;
#(
  parameter int          VA_W     = 16,
  parameter int          OFS_W    = 8,
  parameter int          PPN_W    = 12,
  parameter int          TBL_W    = 2,
  parameter int          DW       = 8,
  parameter logic [15:0] VEC_ADDR = 16'hFFFA
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [VA_W-1:0]        cpu_addr,
  input  logic                   cpu_rd,
  input  logic                   cpu_wr,
  input  logic [DW-1:0]          cpu_wdata,
  output logic [DW-1:0]          cpu_rdata,
  output logic                   nmi_req,
  output logic [PPN_W+OFS_W-1:0] mem_addr,
  output logic                   mem_en,
  output logic                   mem_we,
  output logic [DW-1:0]          mem_wdata,
  input  logic [DW-1:0]          mem_rdata,
  input  logic                   cfg_wr,
  input  logic [2:0]             cfg_addr,
  input  logic [DW-1:0]          cfg_wdata,
  output logic [DW-1:0]          cfg_rdata
);
  localparam int               VPN_W    = VA_W - OFS_W;
  localparam int               NTBL     = 2 ** TBL_W;
  localparam int               RAM_AW   = TBL_W + VPN_W;
  localparam int               ENT_W    = PPN_W + 3;
  localparam logic [TBL_W-1:0] HND_TBL  = TBL_W'(NTBL - 2);
  localparam logic [TBL_W-1:0] DEAD_TBL = TBL_W'(NTBL - 1);

  logic [TBL_W-1:0]  active_tbl, saved_tbl, rd_tbl;
  logic              iso_q, vec_hit, unlocked;
  logic              commit_we, sel_we;
  logic [RAM_AW-1:0] commit_addr;
  logic [ENT_W-1:0]  commit_data, ent_q;
  logic [TBL_W-1:0]  sel_tbl;

  logic              s1_rd, s1_wr, s1_req;
  logic [OFS_W-1:0]  s1_ofs;
  logic [DW-1:0]     s1_wd;
  logic [TBL_W-1:0]  s1_tbl;
  logic              live, perm, viol, fault_evt;

  // Stage 0: choose the table and start the lookup
  assign vec_hit  = cpu_rd && (cpu_addr == VEC_ADDR);
  assign rd_tbl   = vec_hit ? HND_TBL : active_tbl;
  assign unlocked = (active_tbl == HND_TBL);

  pgmmu_xlat_ram #(.AW(RAM_AW), .DW(ENT_W)) u_ram (
    .clk   (clk),
    .we    (commit_we),
    .waddr (commit_addr),
    .wdata (commit_data),
    .raddr ({rd_tbl, cpu_addr[VA_W-1:OFS_W]}),
    .rdata (ent_q)
  );

  pgmmu_cfg #(.VPN_W(VPN_W), .PPN_W(PPN_W), .TBL_W(TBL_W), .DW(DW)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .wr          (cfg_wr),
    .addr        (cfg_addr),
    .wdata       (cfg_wdata),
    .unlocked    (unlocked),
    .commit_we   (commit_we),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .sel_we      (sel_we),
    .sel_tbl     (sel_tbl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_rd <= 1'b0;
      s1_wr <= 1'b0;
    end else begin
      s1_rd <= cpu_rd;
      s1_wr <= cpu_wr;
    end
    s1_ofs <= cpu_addr[OFS_W-1:0];
    s1_wd  <= cpu_wdata;
    s1_tbl <= rd_tbl;
  end

  // Stage 1: permission check and memory cycle
  assign s1_req    = s1_rd || s1_wr;
  assign live      = ent_q[ENT_W-1] && (s1_tbl != DEAD_TBL);
  assign perm      = s1_rd ? ent_q[ENT_W-3] : ent_q[ENT_W-2];
  assign viol      = s1_req && !(live && perm);
  assign fault_evt = viol && !iso_q;

  assign mem_en    = s1_req && live && perm && !iso_q;
  assign mem_we    = mem_en && s1_wr;
  assign mem_addr  = {ent_q[PPN_W-1:0], s1_ofs};
  assign mem_wdata = s1_wd;

  pgmmu_fault_ctl #(.TBL_W(TBL_W), .HND_TBL(HND_TBL), .DEAD_TBL(DEAD_TBL)) u_fault (
    .clk        (clk),
    .rst        (rst),
    .fault_evt  (fault_evt),
    .fault_tbl  (s1_tbl),
    .vec_hit    (vec_hit),
    .sel_we     (sel_we),
    .sel_tbl    (sel_tbl),
    .active_tbl (active_tbl),
    .saved_tbl  (saved_tbl),
    .iso_q      (iso_q)
  );

  assign nmi_req = iso_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      cfg_rdata <= '0;
    end else begin
      if (s1_rd) cpu_rdata <= mem_en ? mem_rdata : '0;
      cfg_rdata <= DW'((cfg_addr == REG_INFO) ? saved_tbl : active_tbl);
    end
  end
endmodule

// File: rtl/page_guard_mmu_chk.sv
module page_guard_mmu_chk
  import pgmmu_pkg::*;
#(
  parameter int               VA_W     = 16,
  parameter int               TBL_W    = 2,
  parameter int               DW       = 8,
  parameter logic [15:0]      VEC_ADDR = 16'hFFFA,
  parameter logic [TBL_W-1:0] HND_TBL  = 2,
  parameter logic [TBL_W-1:0] DEAD_TBL = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_rd,
  input logic [VA_W-1:0]  cpu_addr,
  input logic             mem_en,
  input logic             mem_we,
  input logic             nmi_req,
  input logic [DW-1:0]    cpu_rdata,
  input logic             cfg_wr,
  input logic [2:0]       cfg_addr,
  input logic [TBL_W-1:0] active_tbl,
  input logic             s1_rd,
  input logic             fault_evt
);
  assert_we_gated_R1: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  assert_rdzero_R3: assert property (@(posedge clk) disable iff (rst)
    (s1_rd && !mem_en) |=> (cpu_rdata == '0));

  assert_isolate_R6: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> !mem_en);

  assert_fault_nmi_R7: assert property (@(posedge clk) disable iff (rst)
    fault_evt |=> nmi_req);

  assert_dead_sel_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_req) |-> (active_tbl == DEAD_TBL));

  assert_vector_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == VEC_ADDR && !fault_evt) |=> (active_tbl == HND_TBL && !nmi_req));

  assert_lock_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == REG_SEL && active_tbl != HND_TBL && !fault_evt
     && !(cpu_rd && cpu_addr == VEC_ADDR)) |=> $stable(active_tbl));
endmodule

bind page_guard_mmu page_guard_mmu_chk #(
  .VA_W(VA_W), .TBL_W(TBL_W), .DW(DW), .VEC_ADDR(VEC_ADDR),
  .HND_TBL(HND_TBL), .DEAD_TBL(DEAD_TBL)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_rd     (cpu_rd),
  .cpu_addr   (cpu_addr),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .nmi_req    (nmi_req),
  .cpu_rdata  (cpu_rdata),
  .cfg_wr     (cfg_wr),
  .cfg_addr   (cfg_addr),
  .active_tbl (active_tbl),
  .s1_rd      (s1_rd),
  .fault_evt  (fault_evt)
);

// File: tb/test_page_guard_mmu.sv
module test_page_guard_mmu;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        nmi_req;
  logic [19:0] mem_addr;
  logic        mem_en, mem_we;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        cfg_wr;
  logic [2:0]  cfg_addr;
  logic [7:0]  cfg_wdata, cfg_rdata;

  int total = 0;
  int bad   = 0;
  int wr_seen = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] model(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]};
  endfunction
  function automatic logic [11:0] ppn0(input logic [7:0] p);
    return {p[3:0], p ^ 8'h5A};
  endfunction
  function automatic logic [11:0] ppn1(input logic [7:0] p);
    return {4'h2, p};
  endfunction
  function automatic logic [11:0] ppn2(input logic [7:0] p);
    return {4'h1, p};
  endfunction

  assign mem_rdata = model(mem_addr);

  page_guard_mmu i_page_guard_mmu (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .nmi_req(nmi_req),
    .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  always @(negedge clk) if (mem_en && mem_we) wr_seen++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgw(input logic [2:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfgr(input logic [2:0] a, output logic [7:0] d);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic load(input logic [7:0] p, input logic [11:0] ppn,
                      input logic v, input logic w, input logic r);
    cfgw(3'd0, p);
    cfgw(3'd2, ppn[7:0]);
    cfgw(3'd3, {v, w, r, 1'b0, ppn[11:8]});
  endtask

  task automatic bus(input logic rd, input logic wr, input logic [15:0] a, input logic [7:0] d);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic take_nmi;
    logic [7:0] v;
    bus(1'b1, 1'b0, 16'hFFFA, 8'h00);
    chk("R8 vector mem_en", 32'(mem_en), 32'd1);
    chk("R8 vector mem_addr", 32'(mem_addr), 32'({ppn2(8'hFF), 8'hFA}));
    chk("R8 nmi dropped", 32'(nmi_req), 32'd0);
    @(negedge clk);
    chk("R8 vector data", 32'(cpu_rdata), 32'(model({ppn2(8'hFF), 8'hFA})));
    cfgr(3'd4, v);
    chk("R8 handler active", 32'(v), 32'd2);
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int w0;
    rst = 1'b1; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10 reset nmi", 32'(nmi_req), 32'd0);
    chk("R10 reset mem_en", 32'(mem_en), 32'd0);
    cfgr(3'd4, v); chk("R10 reset active", 32'(v), 32'd2);
    cfgr(3'd5, v); chk("R11 reset saved", 32'(v), 32'd0);

    // Boot configuration in the handler table
    cfgw(3'd1, 8'd0);
    for (int p = 0; p < 256; p++) load(8'(p), ppn0(8'(p)), (p != 8'hE0), 1'b1, 1'b1);
    cfgw(3'd1, 8'd1);
    for (int p = 0; p < 256; p++) begin
      logic [7:0] pg;
      pg = 8'(p);
      load(pg, ppn1(pg), pg != 8'h21, !(pg == 8'h67 || pg == 8'h68), !(pg == 8'h68 || pg == 8'h22));
    end
    cfgw(3'd1, 8'd2);
    for (int p = 0; p < 256; p++) load(8'(p), ppn2(8'(p)), 1'b1, 1'b1, 1'b1);
    cfgw(3'd4, 8'd0);
    cfgr(3'd4, v); chk("R9 select in handler", 32'(v), 32'd0);

    // Read sweep through table 0
    for (int p = 0; p < 256; p++) begin
      logic [7:0] pg;
      logic [19:0] ea;
      pg = 8'(p);
      ea = {ppn0(pg), pg ^ 8'h3C};
      if (pg != 8'hE0) begin
        bus(1'b1, 1'b0, {pg, pg ^ 8'h3C}, 8'h00);
        chk("R1 read mem_en", 32'(mem_en), 32'd1);
        chk("R1 read mem_we", 32'(mem_we), 32'd0);
        chk("R1 read mem_addr", 32'(mem_addr), 32'(ea));
        @(negedge clk);
        chk("R2 read data", 32'(cpu_rdata), 32'(model(ea)));
      end
    end

    // Write sweep through table 0
    w0 = wr_seen;
    for (int p = 0; p < 256; p++) begin
      logic [7:0] pg;
      pg = 8'(p);
      if (pg != 8'hE0) begin
        bus(1'b0, 1'b1, {pg, ~pg}, pg ^ 8'hA5);
        chk("R1 write mem_we", 32'(mem_we), 32'd1);
        chk("R1 write mem_addr", 32'(mem_addr), 32'({ppn0(pg), ~pg}));
        chk("R1 write data", 32'(mem_wdata), 32'(pg ^ 8'hA5));
      end
    end
    @(negedge clk);
    chk("R1 write count", 32'(wr_seen - w0), 32'd255);

    // Locked register port outside the handler table
    cfgw(3'd0, 8'h10); cfgw(3'd2, 8'h00); cfgw(3'd3, 8'h00); cfgw(3'd4, 8'd1);
    cfgr(3'd4, v); chk("R9 select ignored", 32'(v), 32'd0);
    bus(1'b1, 1'b0, 16'h1040, 8'h00);
    chk("R9 entry unchanged en", 32'(mem_en), 32'd1);
    chk("R9 entry unchanged addr", 32'(mem_addr), 32'({ppn0(8'h10), 8'h40}));
    @(negedge clk);

    // Invalid entry in table 0
    bus(1'b1, 1'b0, 16'hE012, 8'h00);
    chk("R5 invalid blocked", 32'(mem_en), 32'd0);
    @(negedge clk);
    chk("R7 nmi raised", 32'(nmi_req), 32'd1);
    chk("R3 blocked read zero", 32'(cpu_rdata), 32'd0);
    cfgr(3'd5, v); chk("R7 saved table 0", 32'(v), 32'd0);
    cfgr(3'd4, v); chk("R7 dead active", 32'(v), 32'd3);
    w0 = wr_seen;
    bus(1'b0, 1'b1, 16'h1000, 8'h77);
    chk("R6 write isolated", 32'(mem_en), 32'd0);
    bus(1'b1, 1'b0, 16'h1001, 8'h00);
    chk("R6 read isolated", 32'(mem_en), 32'd0);
    @(negedge clk);
    chk("R6 read zero", 32'(cpu_rdata), 32'd0);
    chk("R6 no writes", 32'(wr_seen - w0), 32'd0);
    cfgw(3'd4, 8'd0);
    cfgr(3'd4, v); chk("R9 locked while dead", 32'(v), 32'd3);
    take_nmi();

    // Opcode on permitted page, operands on forbidden page, then a store
    cfgw(3'd4, 8'd1);
    bus(1'b1, 1'b0, 16'h6710, 8'h00);
    chk("R1 table1 addr", 32'(mem_addr), 32'({ppn1(8'h67), 8'h10}));
    @(negedge clk);
    w0 = wr_seen;
    bus(1'b1, 1'b0, 16'h67FF, 8'h00);
    chk("R6 opcode fetch", 32'(mem_en), 32'd1);
    bus(1'b1, 1'b0, 16'h6800, 8'h00);
    chk("R3 operand blocked", 32'(mem_en), 32'd0);
    bus(1'b1, 1'b0, 16'h6801, 8'h00);
    chk("R6 second operand", 32'(mem_en), 32'd0);
    bus(1'b0, 1'b1, 16'hC023, 8'h55);
    chk("R6 intended store", 32'(mem_en), 32'd0);
    bus(1'b0, 1'b1, 16'h0000, 8'h55);
    chk("R6 bogus store", 32'(mem_en), 32'd0);
    @(negedge clk);
    chk("R6 corner no writes", 32'(wr_seen - w0), 32'd0);
    chk("R7 corner nmi", 32'(nmi_req), 32'd1);
    cfgr(3'd5, v); chk("R7 saved table 1", 32'(v), 32'd1);
    take_nmi();

    // Write to a read-only page
    cfgw(3'd4, 8'd1);
    bus(1'b0, 1'b1, 16'h6705, 8'hAA);
    chk("R4 write blocked", 32'(mem_en | mem_we), 32'd0);
    @(negedge clk);
    chk("R4 write fault nmi", 32'(nmi_req), 32'd1);
    take_nmi();

    // Write-only page: write passes, read faults
    cfgw(3'd4, 8'd1);
    bus(1'b0, 1'b1, 16'h2201, 8'h3C);
    chk("R4 write-only passes", 32'(mem_we), 32'd1);
    chk("R4 write-only addr", 32'(mem_addr), 32'({ppn1(8'h22), 8'h01}));
    bus(1'b1, 1'b0, 16'h2200, 8'h00);
    chk("R3 no-read blocked", 32'(mem_en), 32'd0);
    @(negedge clk);
    chk("R3 no-read zero", 32'(cpu_rdata), 32'd0);
    chk("R3 no-read nmi", 32'(nmi_req), 32'd1);
    take_nmi();

    // Invalid entry in table 1
    cfgw(3'd4, 8'd1);
    bus(1'b1, 1'b0, 16'h2130, 8'h00);
    chk("R5 table1 invalid", 32'(mem_en), 32'd0);
    @(negedge clk);
    chk("R5 invalid nmi", 32'(nmi_req), 32'd1);
    take_nmi();

    // Dead table selected directly
    cfgw(3'd4, 8'd3);
    bus(1'b1, 1'b0, 16'h1000, 8'h00);
    chk("R5 dead table blocked", 32'(mem_en), 32'd0);
    @(negedge clk);
    chk("R5 dead table nmi", 32'(nmi_req), 32'd1);
    cfgr(3'd5, v); chk("R11 saved dead", 32'(v), 32'd3);
    take_nmi();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule